// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Front End

This block is the register side of a serial port. A processor reaches it through a plain 32-bit word read/write port. Characters written to the transmit window are queued in a 64-entry transmit FIFO. The serial framer outside the block drains that FIFO through a take strobe. Characters that the framer receives are pushed into a 64-entry receive FIFO, and software pops them by reading the receive window. The framer and the baud generator are not part of this block. They receive the control and divisor register values on output buses.

The block gathers FIFO levels and three sticky error conditions into a status word. It raises a single interrupt line from two enabled level comparisons against thresholds that software programs. The error-clear and FIFO-flush controls are level bits in the control register, not self-clearing bits. Software writes a 1 and then a 0. The action lasts for every cycle the bit stays at 1.

Top module: `uart_fifo_irq_regs`

## Requirements
- R1: After reset the control, threshold and divisor registers read 0, the irq output is low, and the status word (offset 0x0C) reads 0x0050_0000: receive-empty (bit 20) and transmit-empty (bit 22) set, all other bits 0.
- R2: Bus writes to offset 0x00 queue wrData[7:0] in order. The queue holds up to 64 characters. txAvail is high and txChar shows the oldest character while the queue is not empty, and a txTake pulse removes that character. Status bit 21 is set exactly when 64 characters are queued, and status bit 22 is set exactly when none are.
- R3: A write to offset 0x00 while 64 characters are queued is dropped and leaves the queue unchanged. It sets the sticky write-error flag, status bit 18.
- R4: An rxPush pulse stores rxChar in the receive queue. A read of offset 0x04 returns the oldest stored character in bits 7:0, with bits 31:8 at zero, and removes it. Status bit 20 is set exactly when the receive queue is empty.
- R5: A read of offset 0x04 while the receive queue is empty returns 0 and removes nothing.
- R6: An rxPush while 64 characters are in the receive queue is dropped, and the stored contents stay unchanged.
- R7: A pulse on rxParityErr sets status bit 16, and a pulse on rxFrameErr sets status bit 17. Each flag stays set until it is cleared.
- R8: While control bit 24 is 1, status bits 16, 17 and 18 are held at 0, and a clear takes precedence over a set in the same cycle. After the bit returns to 0, the flags stay 0 until a new error occurs.
- R9: While control bit 22 is 1 the transmit queue is emptied and bus writes to offset 0x00 are ignored. While control bit 23 is 1 the receive queue is emptied and rxPush is ignored.
- R10: The receive interrupt condition is control bit 27 set and a receive queue count at or above threshold bits 7:0 (offset 0x10).
- R11: The transmit interrupt condition is control bit 28 set and a transmit queue count below threshold bits 15:8. irq is the OR of the receive and transmit conditions.
- R12: The control (0x08), threshold (0x10) and divisor (0x14) registers read back the last value written. cfgCtrl and cfgBaud output the control and divisor values. Status bit 25 follows the txBusy input, and reads of offset 0x00 or of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte offset of the accessed register |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read; pops the receive queue at offset 0x04 |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, valid in the cycle of the read |
| txAvail | output | 1 | Transmit queue holds at least one character |
| txChar | output | 8 | Oldest queued transmit character |
| txTake | input | 1 | Framer takes the oldest transmit character |
| txBusy | input | 1 | Framer shifter is active |
| rxPush | input | 1 | Framer delivers a received character |
| rxChar | input | 8 | Received character |
| rxParityErr | input | 1 | Parity error event from the framer |
| rxFrameErr | input | 1 | Framing error event from the framer |
| irq | output | 1 | Combined interrupt request |
| cfgCtrl | output | 32 | Control register value for the framer |
| cfgBaud | output | 32 | Divisor register value for the baud generator |

## Verification
The assertions check on every cycle that both queue counts stay within 64 and that a full-queue write raises the write-error flag. They also check that an empty-queue read and a full-queue push leave the receive count unchanged, that a held clear or flush takes effect by the next cycle, and that irq stays low while both enables are off. Character ordering, the value returned by a pop, the exact threshold edges of both interrupt conditions, and the persistence of the sticky flags after a clear is released depend on data and history. Only the bench's scenarios can show these, by comparing every port against a queue model.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_TXQ  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RXQ  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_LVL  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h14;

  localparam int ST_PAR   = 16;
  localparam int ST_FRM   = 17;
  localparam int ST_WERR  = 18;
  localparam int ST_RXEMP = 20;
  localparam int ST_TXFUL = 21;
  localparam int ST_TXEMP = 22;
  localparam int ST_BUSY  = 25;

  localparam int CT_TXFLUSH = 22;
  localparam int CT_RXFLUSH = 23;
  localparam int CT_ERRCLR  = 24;
  localparam int CT_RXIE    = 27;
  localparam int CT_TXIE    = 28;

  typedef struct packed {
    logic txWr;
    logic rxRd;
    logic txFlush;
    logic rxFlush;
    logic errClr;
  } fe_strobe_t;
endpackage

// File: rtl/uart_fe_fifo.sv
module uart_fe_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/uart_fe_ctrl.sv
module uart_fe_ctrl
  import uart_fe_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] statusWord,
  input  logic [CHAR_W-1:0] rxHead,
  input  logic              rxEmpty,
  output logic [DATA_W-1:0] busRdata,
  output fe_strobe_t        strb,
  output logic [DATA_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] lvlReg,
  output logic [DATA_W-1:0] divReg
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      lvlReg  <= '0;
      divReg  <= '0;
    end else if (busWr) begin
      case (busAddr)
        OFS_CTRL: ctrlReg <= busWdata;
        OFS_LVL:  lvlReg  <= busWdata;
        OFS_DIV:  divReg  <= busWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.txWr    = busWr && (busAddr == OFS_TXQ);
    strb.rxRd    = busRd && (busAddr == OFS_RXQ);
    strb.txFlush = ctrlReg[CT_TXFLUSH];
    strb.rxFlush = ctrlReg[CT_RXFLUSH];
    strb.errClr  = ctrlReg[CT_ERRCLR];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_RXQ:  if (!rxEmpty) busRdata[CHAR_W-1:0] = rxHead;
      OFS_CTRL: busRdata = ctrlReg;
      OFS_STAT: busRdata = statusWord;
      OFS_LVL:  busRdata = lvlReg;
      OFS_DIV:  busRdata = divReg;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_fe_dp.sv
module uart_fe_dp
  import uart_fe_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fe_strobe_t        strb,
  input  logic [CHAR_W-1:0] wrChar,
  input  logic              rxIrqEn,
  input  logic              txIrqEn,
  input  logic [LVL_W-1:0]  rxLvl,
  input  logic [LVL_W-1:0]  txLvl,
  input  logic              txTake,
  input  logic              txBusy,
  input  logic              rxPush,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  output logic [DATA_W-1:0] statusWord,
  output logic [CHAR_W-1:0] rxHead,
  output logic              rxEmpty,
  output logic [CHAR_W-1:0] txHead,
  output logic              txAvail,
  output logic              irq,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount
);
  localparam int CMP_W = (CW > LVL_W) ? CW : LVL_W;

  logic txFull, txEmpty, rxFull;
  logic parErr, frmErr, wrErr;
  logic setWrErr;

  uart_fe_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_txq (
    .clk(clk), .rstN(rstN), .flush(strb.txFlush),
    .push(strb.txWr), .pop(txTake), .din(wrChar),
    .dout(txHead), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  uart_fe_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_rxq (
    .clk(clk), .rstN(rstN), .flush(strb.rxFlush),
    .push(rxPush), .pop(strb.rxRd), .din(rxChar),
    .dout(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  assign setWrErr = strb.txWr && txFull && !strb.txFlush;
  assign txAvail  = !txEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parErr <= 1'b0;
      frmErr <= 1'b0;
      wrErr  <= 1'b0;
    end else if (strb.errClr) begin
      parErr <= 1'b0;
      frmErr <= 1'b0;
      wrErr  <= 1'b0;
    end else begin
      parErr <= parErr | rxParityErr;
      frmErr <= frmErr | rxFrameErr;
      wrErr  <= wrErr | setWrErr;
    end
  end

  always_comb begin
    statusWord           = '0;
    statusWord[ST_PAR]   = parErr;
    statusWord[ST_FRM]   = frmErr;
    statusWord[ST_WERR]  = wrErr;
    statusWord[ST_RXEMP] = rxEmpty;
    statusWord[ST_TXFUL] = txFull;
    statusWord[ST_TXEMP] = txEmpty;
    statusWord[ST_BUSY]  = txBusy;
  end

  logic rxHit, txHit;
  assign rxHit = rxIrqEn && (CMP_W'(rxCount) >= CMP_W'(rxLvl));
  assign txHit = txIrqEn && (CMP_W'(txCount) <  CMP_W'(txLvl));
  assign irq   = rxHit || txHit;

  logic unusedRxFull;
  assign unusedRxFull = rxFull;
endmodule

// File: rtl/uart_fifo_irq_regs.sv
module uart_fifo_irq_regs
  import uart_fe_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              txAvail,
  output logic [CHAR_W-1:0] txChar,
  input  logic              txTake,
  input  logic              txBusy,
  input  logic              rxPush,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  output logic              irq,
  output logic [31:0]       cfgCtrl,
  output logic [31:0]       cfgBaud
);
  fe_strobe_t        strb;
  logic [31:0]       statusWord, lvlReg;
  logic [CHAR_W-1:0] rxHead;
  logic              rxEmpty;
  logic [CW-1:0]     txCount, rxCount;

  uart_fe_ctrl #(.CHAR_W(CHAR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .statusWord(statusWord), .rxHead(rxHead), .rxEmpty(rxEmpty),
    .busRdata(busRdata), .strb(strb), .ctrlReg(cfgCtrl), .lvlReg(lvlReg), .divReg(cfgBaud)
  );

  uart_fe_dp #(.DEPTH(DEPTH), .CHAR_W(CHAR_W), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrChar(busWdata[CHAR_W-1:0]),
    .rxIrqEn(cfgCtrl[CT_RXIE]), .txIrqEn(cfgCtrl[CT_TXIE]),
    .rxLvl(lvlReg[LVL_W-1:0]), .txLvl(lvlReg[2*LVL_W-1:LVL_W]),
    .txTake(txTake), .txBusy(txBusy), .rxPush(rxPush), .rxChar(rxChar),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .statusWord(statusWord), .rxHead(rxHead), .rxEmpty(rxEmpty),
    .txHead(txChar), .txAvail(txAvail), .irq(irq),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: rtl/uart_fifo_irq_regs_chk.sv
module uart_fifo_irq_regs_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic [4:0]    busAddr,
  input logic          busWr,
  input logic          busRd,
  input logic          rxPush,
  input logic          irq,
  input logic          txFlush,
  input logic          rxFlush,
  input logic          errClr,
  input logic          rxIe,
  input logic          txIe,
  input logic [2:0]    errBits,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= FULLV) && (rxCount <= FULLV)); // R2

  AST_FULL_WRITE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 5'h00 && txCount == FULLV && !txFlush && !errClr) |=> errBits[2]); // R3

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 5'h04 && rxCount == '0 && !rxPush) |=> (rxCount == '0)); // R5

  AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxCount == FULLV && !(busRd && busAddr == 5'h04) && !rxFlush) |=> (rxCount == FULLV)); // R6

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    errClr |=> (errBits == 3'b000)); // R8

  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    txFlush |=> (txCount == '0)); // R9

  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    rxFlush |=> (rxCount == '0)); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!rxIe && !txIe) |-> !irq); // R10 R11
endmodule

bind uart_fifo_irq_regs uart_fifo_irq_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .rxPush(rxPush), .irq(irq),
  .txFlush(cfgCtrl[22]), .rxFlush(cfgCtrl[23]), .errClr(cfgCtrl[24]),
  .rxIe(cfgCtrl[27]), .txIe(cfgCtrl[28]),
  .errBits(statusWord[18:16]), .txCount(txCount), .rxCount(rxCount)
);

// File: tb/uart_fifo_irq_regs_tb.sv
`timescale 1ns/1ps
module uart_fifo_irq_regs_tb;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txAvail;
  logic [7:0]  txChar;
  logic        txTake = 1'b0, txBusy = 1'b0, rxPush = 1'b0;
  logic [7:0]  rxChar = '0;
  logic        rxParityErr = 1'b0, rxFrameErr = 1'b0;
  logic        irq;
  logic [31:0] cfgCtrl, cfgBaud;

  always #2.5 clk = ~clk;

  uart_fifo_irq_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .txAvail(txAvail), .txChar(txChar),
    .txTake(txTake), .txBusy(txBusy), .rxPush(rxPush), .rxChar(rxChar),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr), .irq(irq),
    .cfgCtrl(cfgCtrl), .cfgBaud(cfgBaud)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0]  txQ[$];
  logic [7:0]  rxQ[$];
  logic        mPar = 0, mFrm = 0, mWerr = 0;
  logic [31:0] mCtrl = 0, mLvl = 0, mDiv = 0;

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    s[16] = mPar;
    s[17] = mFrm;
    s[18] = mWerr;
    s[20] = (rxQ.size() == 0);
    s[21] = (txQ.size() == DEPTH);
    s[22] = (txQ.size() == 0);
    s[25] = txBusy;
    return s;
  endfunction

  function automatic logic expIrq();
    logic rxHit = mCtrl[27] && (rxQ.size() >= int'(mLvl[7:0]));
    logic txHit = mCtrl[28] && (txQ.size() <  int'(mLvl[15:8]));
    return rxHit || txHit;
  endfunction

  function automatic logic [31:0] expRead(input logic [4:0] a);
    case (a)
      5'h04: return (rxQ.size() > 0) ? {24'd0, rxQ[0]} : 32'd0;
      5'h08: return mCtrl;
      5'h0C: return expStatus();
      5'h10: return mLvl;
      5'h14: return mDiv;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock cycle: drive, check outputs before the edge, advance the model
  task automatic cyc(input string tag, input bit wr, input bit rd, input logic [4:0] a,
                     input logic [31:0] wd, input bit take, input bit push,
                     input logic [7:0] rc, input bit pe, input bit fe);
    bit txFl, rxFl, clr, full, pushTx, popTx, pushRx, popRx, setW;
    logic [31:0] er;
    busWr = wr; busRd = rd; busAddr = a; busWdata = wd;
    txTake = take; rxPush = push; rxChar = rc; rxParityErr = pe; rxFrameErr = fe;
    #1;
    chk(irq === expIrq(), tag, "irq", {31'd0, irq}, {31'd0, expIrq()});
    chk(txAvail === (txQ.size() > 0), tag, "txAvail", {31'd0, txAvail}, {31'd0, txQ.size() > 0});
    if (txQ.size() > 0) chk(txChar === txQ[0], tag, "txChar", {24'd0, txChar}, {24'd0, txQ[0]});
    chk(cfgCtrl === mCtrl && cfgBaud === mDiv, tag, "cfg", cfgCtrl ^ cfgBaud, mCtrl ^ mDiv);
    if (rd) begin
      er = expRead(a);
      chk(busRdata === er, tag, "rdata", busRdata, er);
    end
    txFl = mCtrl[22]; rxFl = mCtrl[23]; clr = mCtrl[24];
    full   = (txQ.size() == DEPTH);
    pushTx = wr && a == 5'h00 && !full && !txFl;
    setW   = wr && a == 5'h00 && full && !txFl;
    popTx  = take && txQ.size() > 0;
    popRx  = rd && a == 5'h04 && rxQ.size() > 0;
    pushRx = push && rxQ.size() < DEPTH && !rxFl;
    if (txFl) txQ.delete();
    else begin
      if (popTx) void'(txQ.pop_front());
      if (pushTx) txQ.push_back(wd[7:0]);
    end
    if (rxFl) rxQ.delete();
    else begin
      if (popRx) void'(rxQ.pop_front());
      if (pushRx) rxQ.push_back(rc);
    end
    if (clr) begin mPar = 0; mFrm = 0; mWerr = 0; end
    else begin mPar |= pe; mFrm |= fe; mWerr |= setW; end
    if (wr && a == 5'h08) mCtrl = wd;
    if (wr && a == 5'h10) mLvl = wd;
    if (wr && a == 5'h14) mDiv = wd;
    @(posedge clk);
    @(negedge clk);
    busWr = 0; busRd = 0; txTake = 0; rxPush = 0; rxParityErr = 0; rxFrameErr = 0;
  endtask

  task automatic wrReg(input string tag, input logic [4:0] a, input logic [31:0] d);
    cyc(tag, 1, 0, a, d, 0, 0, 8'h00, 0, 0);
  endtask
  task automatic rdReg(input string tag, input logic [4:0] a);
    cyc(tag, 0, 1, a, 32'd0, 0, 0, 8'h00, 0, 0);
  endtask
  task automatic idle(input string tag);
    cyc(tag, 0, 0, 5'h1C, 32'd0, 0, 0, 8'h00, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rdReg("R1", 5'h0C);
    rdReg("R1", 5'h08);
    rdReg("R1", 5'h10);
    rdReg("R1", 5'h14);

    // R2 fill the transmit queue, R3 overflow write
    for (int i = 0; i < DEPTH; i++) wrReg("R2", 5'h00, 32'hA500 + i);
    rdReg("R2", 5'h0C);
    wrReg("R3", 5'h00, 32'h0000_00EE);
    rdReg("R3", 5'h0C);
    idle("R3");
    rdReg("R3", 5'h0C);

    // R8 error clear held, then released
    wrReg("R8", 5'h08, 32'h0100_0000);
    wrReg("R8", 5'h00, 32'h0000_0011);
    rdReg("R8", 5'h0C);
    wrReg("R8", 5'h08, 32'h0);
    idle("R8");
    rdReg("R8", 5'h0C);

    // R2 drain in order through the take strobe
    for (int i = 0; i < DEPTH; i++) cyc("R2", 0, 0, 5'h1C, 0, 1, 0, 0, 0, 0);
    rdReg("R2", 5'h0C);

    // R4, R6 fill the receive queue beyond capacity
    for (int i = 0; i < DEPTH + 2; i++) cyc("R6", 0, 0, 5'h1C, 0, 0, 1, 8'(i * 7 + 3), 0, 0);
    rdReg("R6", 5'h0C);
    for (int i = 0; i < DEPTH; i++) rdReg("R4", 5'h04);
    rdReg("R4", 5'h0C);
    // R5 empty read returns zero and removes nothing
    rdReg("R5", 5'h04);
    rdReg("R5", 5'h04);
    cyc("R5", 0, 0, 5'h1C, 0, 0, 1, 8'h5A, 0, 0);
    rdReg("R5", 5'h04);
    rdReg("R5", 5'h0C);

    // R7 sticky parity and framing flags
    cyc("R7", 0, 0, 5'h1C, 0, 0, 0, 0, 1, 0);
    idle("R7");
    rdReg("R7", 5'h0C);
    cyc("R7", 0, 0, 5'h1C, 0, 0, 0, 0, 0, 1);
    rdReg("R7", 5'h0C);
    // R8 clear wins over a simultaneous set
    wrReg("R8", 5'h08, 32'h0100_0000);
    cyc("R8", 0, 0, 5'h1C, 0, 0, 0, 0, 1, 1);
    rdReg("R8", 5'h0C);
    wrReg("R8", 5'h08, 32'h0);
    rdReg("R8", 5'h0C);

    // R9 flush controls
    for (int i = 0; i < 5; i++) wrReg("R9", 5'h00, 32'h30 + i);
    for (int i = 0; i < 4; i++) cyc("R9", 0, 0, 5'h1C, 0, 0, 1, 8'h40 + 8'(i), 0, 0);
    wrReg("R9", 5'h08, 32'h00C0_0000);
    wrReg("R9", 5'h00, 32'h77);
    cyc("R9", 0, 0, 5'h1C, 0, 0, 1, 8'h88, 0, 0);
    rdReg("R9", 5'h0C);
    wrReg("R9", 5'h08, 32'h0);
    rdReg("R9", 5'h0C);
    rdReg("R9", 5'h04);

    // R10 receive level, R11 transmit level
    wrReg("R10", 5'h10, 32'h0000_0203);
    wrReg("R10", 5'h08, 32'h0800_0000);
    for (int i = 0; i < 4; i++) cyc("R10", 0, 0, 5'h1C, 0, 0, 1, 8'h61 + 8'(i), 0, 0);
    for (int i = 0; i < 4; i++) rdReg("R10", 5'h04);
    wrReg("R11", 5'h08, 32'h1000_0000);
    for (int i = 0; i < 3; i++) wrReg("R11", 5'h00, 32'h90 + i);
    for (int i = 0; i < 3; i++) cyc("R11", 0, 0, 5'h1C, 0, 1, 0, 0, 0, 0);
    wrReg("R11", 5'h10, 32'h0000_0000);
    wrReg("R11", 5'h08, 32'h1800_0000);
    idle("R11");

    // R12 readback, busy bit, unmapped offsets
    wrReg("R12", 5'h14, 32'h00AB_CDEF);
    wrReg("R12", 5'h10, 32'h1234_5678);
    rdReg("R12", 5'h14);
    rdReg("R12", 5'h10);
    rdReg("R12", 5'h08);
    txBusy = 1'b1;
    rdReg("R12", 5'h0C);
    txBusy = 1'b0;
    rdReg("R12", 5'h0C);
    rdReg("R12", 5'h00);
    rdReg("R12", 5'h18);
    wrReg("R12", 5'h08, 32'h0);

    // mixed random traffic, all checks against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom % 16;
      case (r)
        0, 1, 2, 3: cyc("R2", 1, 0, 5'h00, $urandom, bit'($urandom % 2), 0, 0, 0, 0);
        4, 5:       cyc("R2", 0, 0, 5'h1C, 0, 1, 0, 0, 0, 0);
        6, 7, 8:    cyc("R4", 0, 0, 5'h1C, 0, 0, 1, 8'($urandom),
                        bit'($urandom % 8 == 0), bit'($urandom % 8 == 0));
        9, 10:      cyc("R4", 0, 1, 5'h04, 0, 0, bit'($urandom % 2), 8'($urandom), 0, 0);
        11:         rdReg("R7", 5'h0C);
        12: begin
          logic [31:0] v = '0;
          v[27] = bit'($urandom % 2);
          v[28] = bit'($urandom % 2);
          v[22] = ($urandom % 8 == 0);
          v[23] = ($urandom % 8 == 0);
          v[24] = ($urandom % 6 == 0);
          wrReg("R9", 5'h08, v);
        end
        13:         wrReg("R10", 5'h10, {16'd0, 8'($urandom % 70), 8'($urandom % 70)});
        14: begin
          txBusy = bit'($urandom % 2);
          idle("R11");
        end
        default:    rdReg("R12", 5'(($urandom % 6) * 4));
      endcase
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule